// File: doc/BRIEF.md
# Interrupt Vector Fetch Sequencer

This block performs interrupt dispatch for a segmented 16-bit processor. A caller presents an 8-bit interrupt type with a one-cycle start strobe. The sequencer then reads two 16-bit words from a 1 KB vector table at the bottom of a 20-bit physical space, each type owning a 4-byte slot. The word at the lower address of the slot is the new instruction offset. The word two bytes above it is the new code segment. Both registers change in the same cycle, and only once both reads are finished. A one-cycle completion pulse follows.

Out of reset the code segment and instruction offset point at the bootstrap entry sixteen bytes below the top of the physical space. The block always drives the physical fetch address built from the two registers. Memory is reached through a simple word-read port. The port holds a request and its address until an acknowledge arrives with the data, so the memory may insert any number of wait cycles.

Top module: `ivt_dispatch`

## Requirements
- R1: While reset is asserted and after it is released with no start, codeSeg is FFFFh, instrOfs is 0000h, fetchAddr is FFFF0h, and memReq, busy and done are all 0.
- R2: In the cycle after an accepted start, memReq is 1 and memAddr equals type*4, which is the type in bits 9:2 with all other bits zero. This read fetches the offset word.
- R3: In the cycle after the first acknowledge, memReq stays 1 and memAddr equals type*4+2, which fetches the segment word.
- R4: While memReq is 1 and memAck is 0, memReq stays 1 and memAddr keeps its value in the next cycle.
- R5: codeSeg and instrOfs keep their old values until the second acknowledge. In the cycle after it, instrOfs equals the first word read and codeSeg equals the second word read, and both change together.
- R6: done is 1 for exactly one cycle, the cycle after the second acknowledge. That is the first cycle in which the new codeSeg and instrOfs are visible. busy is 1 from the cycle after an accepted start through the done cycle.
- R7: fetchAddr equals codeSeg*16 + instrOfs, truncated to 20 bits, at all times.
- R8: startReq has no effect while busy is 1, including in the done cycle. The address, the results and the read sequence stay those of the sequence already running, and no read follows the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| startReq | input | 1 | One-cycle request to dispatch intType |
| intType | input | 8 | Interrupt type, sampled with an accepted startReq |
| memReq | output | 1 | Word read request, held until memAck |
| memAddr | output | 20 | Byte address of the word being read |
| memAck | input | 1 | Read complete; memData is valid in this cycle |
| memData | input | 16 | Read data |
| busy | output | 1 | A dispatch sequence is in progress |
| done | output | 1 | One-cycle pulse: new codeSeg/instrOfs are in place |
| codeSeg | output | 16 | Code segment register |
| instrOfs | output | 16 | Instruction offset register |
| fetchAddr | output | 20 | Physical fetch address from codeSeg and instrOfs |

## Verification
Two events can land in the same cycle: a fresh start strobe can arrive while a sequence is still running. It can coincide with a wait cycle of the offset read, or with the done pulse. The bench sweeps all 256 types with varying wait counts. In the first wait cycle of the offset read, and again in the done cycle, it pulses startReq with a different type. It then checks that memAddr still carries the original slot, that codeSeg and instrOfs hold the original type's words, and that memReq stays low after done.

// File: rtl/ivt_dispatch_pkg.sv
package ivt_dispatch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD_OFS = 2'd1,
    ST_RD_SEG = 2'd2,
    ST_DONE = 2'd3
  } vecState_t;

  typedef struct packed {
    logic loadType;
    logic capOfs;
    logic commit;
    logic selSeg;
  } vecStrb_t;

endpackage

// File: rtl/ivt_dispatch_ctrl.sv
module ivt_dispatch_ctrl
  import ivt_dispatch_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     memAck,
  output logic     memReq,
  output logic     busy,
  output logic     done,
  output vecStrb_t strb
);

  vecState_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strb     = '0;
    memReq   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          strb.loadType = 1'b1;
          stateNxt      = ST_RD_OFS;
        end
      end
      ST_RD_OFS: begin
        memReq = 1'b1;
        if (memAck) begin
          strb.capOfs = 1'b1;
          stateNxt    = ST_RD_SEG;
        end
      end
      ST_RD_SEG: begin
        memReq      = 1'b1;
        strb.selSeg = 1'b1;
        if (memAck) begin
          strb.commit = 1'b1;
          stateNxt    = ST_DONE;
        end
      end
      ST_DONE: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq); // R4
  AST_NO_READ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !memReq); // R8
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy); // R6

endmodule

// File: rtl/ivt_dispatch_dpath.sv
module ivt_dispatch_dpath
  import ivt_dispatch_pkg::*;
#(
  parameter int TYPE_W    = 8,
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 4,
  parameter logic [WORD_W-1:0] RESET_CS = 16'hFFFF,
  parameter logic [WORD_W-1:0] RESET_IP = 16'h0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  vecStrb_t          strb,
  input  logic [TYPE_W-1:0] intType,
  input  logic [WORD_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] codeSeg,
  output logic [WORD_W-1:0] instrOfs,
  output logic [ADDR_W-1:0] fetchAddr
);

  localparam int SLOT_BITS = 2;                       // two words of two bytes
  localparam int PAD_W     = ADDR_W - TYPE_W - SLOT_BITS;
  localparam int SEGX_W    = WORD_W + SEG_SHIFT;

  logic [TYPE_W-1:0] typeReg;
  logic [WORD_W-1:0] ofsTmp;
  logic [SEGX_W-1:0] segShifted;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      typeReg  <= '0;
      ofsTmp   <= '0;
      codeSeg  <= RESET_CS;
      instrOfs <= RESET_IP;
    end else begin
      if (strb.loadType) typeReg <= intType;
      if (strb.capOfs)   ofsTmp  <= memData;
      if (strb.commit) begin
        instrOfs <= ofsTmp;
        codeSeg  <= memData;
      end
    end
  end

  assign memAddr    = {{PAD_W{1'b0}}, typeReg, strb.selSeg, 1'b0};
  assign segShifted = {codeSeg, {SEG_SHIFT{1'b0}}};
  assign fetchAddr  = ADDR_W'(segShifted) + ADDR_W'(instrOfs);

  AST_REGS_ATOMIC: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> ($stable(codeSeg) && $stable(instrOfs))); // R5
  AST_TYPE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadType |=> $stable(typeReg)); // R8

endmodule

// File: rtl/ivt_dispatch.sv
module ivt_dispatch
  import ivt_dispatch_pkg::*;
#(
  parameter int TYPE_W = 8,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [TYPE_W-1:0] intType,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [WORD_W-1:0] memData,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] codeSeg,
  output logic [WORD_W-1:0] instrOfs,
  output logic [ADDR_W-1:0] fetchAddr
);

  vecStrb_t strb;

  ivt_dispatch_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .memAck   (memAck),
    .memReq   (memReq),
    .busy     (busy),
    .done     (done),
    .strb     (strb)
  );

  ivt_dispatch_dpath #(
    .TYPE_W (TYPE_W),
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .intType   (intType),
    .memData   (memData),
    .memAddr   (memAddr),
    .codeSeg   (codeSeg),
    .instrOfs  (instrOfs),
    .fetchAddr (fetchAddr)
  );

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> $stable(memAddr)); // R4

endmodule

// File: tb/ivt_dispatch_tb_top.sv
module ivt_dispatch_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [7:0]  intType = '0;
  logic        memReq;
  logic [19:0] memAddr;
  logic        memAck = 1'b0;
  logic [15:0] memData = '0;
  logic        busy;
  logic        done;
  logic [15:0] codeSeg;
  logic [15:0] instrOfs;
  logic [19:0] fetchAddr;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ivt_dispatch dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .intType(intType),
    .memReq(memReq), .memAddr(memAddr), .memAck(memAck), .memData(memData),
    .busy(busy), .done(done), .codeSeg(codeSeg), .instrOfs(instrOfs),
    .fetchAddr(fetchAddr)
  );

  function automatic logic [15:0] memWord(input logic [19:0] a);
    return 16'(32'(a[9:1]) * 32'd40503 + 32'h3C5A);
  endfunction

  function automatic logic [19:0] physAddr(input logic [15:0] s, input logic [15:0] o);
    return 20'((32'(s) * 32'd16 + 32'(o)) % 32'h100000);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      finishRun();
    end
  end

  // one full dispatch; intrude: pulse a foreign start during offset wait and done
  task automatic dispatch(input logic [7:0] t, input int wOfs, input int wSeg,
                          input bit intrude);
    logic [15:0] oldCs, oldIp, expIp, expCs;
    logic [19:0] aOfs, aSeg;
    aOfs  = 20'(t) * 20'd4;
    aSeg  = aOfs + 20'd2;
    expIp = memWord(aOfs);
    expCs = memWord(aSeg);
    oldCs = codeSeg;
    oldIp = instrOfs;
    @(negedge clk);
    startReq = 1'b1;
    intType  = t;
    @(negedge clk);
    startReq = 1'b0;
    intType  = ~t;
    chk(memReq == 1'b1, "R2 memReq", 32'(memReq), 1);
    chk(memAddr == aOfs, "R2 offset addr", 32'(memAddr), 32'(aOfs));
    chk(busy == 1'b1, "R6 busy", 32'(busy), 1);
    for (int i = 0; i < wOfs; i++) begin
      if (intrude && i == 0) startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
      chk(memReq && memAddr == aOfs, "R4 offset hold", 32'(memAddr), 32'(aOfs));
      if (intrude && i == 0)
        chk(memAddr == aOfs, "R8 start in wait", 32'(memAddr), 32'(aOfs));
    end
    memAck  = 1'b1;
    memData = expIp;
    @(negedge clk);
    memAck  = 1'b0;
    memData = 16'hDEAD;
    chk(memReq && memAddr == aSeg, "R3 segment addr", 32'(memAddr), 32'(aSeg));
    chk(codeSeg == oldCs && instrOfs == oldIp, "R5 not yet updated",
        {codeSeg, instrOfs}, {oldCs, oldIp});
    for (int i = 0; i < wSeg; i++) begin
      @(negedge clk);
      chk(memReq && memAddr == aSeg, "R4 segment hold", 32'(memAddr), 32'(aSeg));
      chk(codeSeg == oldCs && instrOfs == oldIp, "R5 hold during wait",
          {codeSeg, instrOfs}, {oldCs, oldIp});
    end
    memAck  = 1'b1;
    memData = expCs;
    @(negedge clk);
    memAck  = 1'b0;
    chk(done == 1'b1 && busy == 1'b1, "R6 done pulse", {done, busy}, 2'b11);
    chk(instrOfs == expIp && codeSeg == expCs, "R5 commit",
        {codeSeg, instrOfs}, {expCs, expIp});
    chk(fetchAddr == physAddr(expCs, expIp), "R7 fetch addr",
        32'(fetchAddr), 32'(physAddr(expCs, expIp)));
    if (intrude) begin
      startReq = 1'b1;
      intType  = t + 8'd1;
    end
    @(negedge clk);
    startReq = 1'b0;
    chk(done == 1'b0 && busy == 1'b0, "R6 done ends", {done, busy}, 0);
    chk(memReq == 1'b0, "R8 no read after done", 32'(memReq), 0);
    chk(instrOfs == expIp && codeSeg == expCs, "R8 results kept",
        {codeSeg, instrOfs}, {expCs, expIp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(codeSeg == 16'hFFFF && instrOfs == 16'h0000, "R1 reset regs in reset",
        {codeSeg, instrOfs}, 32'hFFFF0000);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(codeSeg == 16'hFFFF && instrOfs == 16'h0000, "R1 reset regs",
        {codeSeg, instrOfs}, 32'hFFFF0000);
    chk(fetchAddr == 20'hFFFF0, "R1 boot fetch", 32'(fetchAddr), 32'hFFFF0);
    chk(memReq == 0 && busy == 0 && done == 0, "R1 idle outputs",
        {memReq, busy, done}, 0);
    chk(fetchAddr == physAddr(codeSeg, instrOfs), "R7 fetch at reset",
        32'(fetchAddr), 32'(physAddr(codeSeg, instrOfs)));
    // memAck while idle must not start anything
    memAck = 1'b1;
    @(negedge clk);
    memAck = 1'b0;
    chk(memReq == 0 && codeSeg == 16'hFFFF, "R8 stray ack idle",
        {memReq, codeSeg}, 32'h0FFFF);
    for (int t = 0; t < 256; t++)
      dispatch(8'(t), t % 3, (t / 3) % 3, (t % 5) == 0);
    dispatch(8'hFF, 4, 0, 1'b1);
    dispatch(8'h00, 0, 4, 1'b0);
    // reset returns to boot entry
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(fetchAddr == 20'hFFFF0 && !busy, "R1 reset after dispatch",
        32'(fetchAddr), 32'hFFFF0);
    finishRun();
  end

endmodule